// File: doc/BRIEF.md
# Parallel I/O Port Group Controller

This block is a 24-bit programmable digital I/O group with three 8-bit ports, called A, B and C. Port C is handled as two 4-bit halves, and each half can point in its own direction. An 8-bit control word sets the direction of the four sections. It also chooses whether input sections show the live pin level or a captured copy, and which edge of an external strobe pin counts as an event.

Each strobe event raises a sticky interrupt request. When capture mode is on, the same event also snapshots every section that is currently an input. Software reaches the block through a small register port: a 3-bit address, a write strobe with write data, and a read data bus that is decoded combinationally from the address. The top two control bits select a transfer method. The block stores them and returns them on read, and they change nothing else.

Top module: `pio_port_group`

## Requirements
- R1: After a synchronous active-low reset the control word reads 0x00, the status word reads 0x00, `irq_o` is 0, every output enable is 0 and every output register holds 0.
- R2: Control bit 0 drives `pa_oe` and control bit 1 drives `pb_oe`. A value of 1 makes the port an output and 0 makes it an input.
- R3: Control bit 2 sets the direction of port C bits 3:0, seen on `pc_oe[0]`. Control bit 3 sets the direction of port C bits 7:4, seen on `pc_oe[1]`.
- R4: When control bit 4 is 0, reading an input section returns the pin value present in that cycle.
- R5: When control bit 4 is 1, every input section captures its pins on a strobe event. Reads of that section then return the captured value, whatever the pins do afterwards.
- R6: When control bit 5 is 0, only rising strobe edges are events. When it is 1, only falling edges are. The other edge neither captures data nor raises `irq_o`.
- R7: A strobe event sets `irq_o`, which stays set until software writes 1 to bit 0 of the status register at address 4. Writing 0 there has no effect. If an event and a clear land in the same cycle, `irq_o` stays set.
- R8: Writing a port (A at address 0, B at 1, C at 2) loads its output register, whatever the direction. The `*_pin_o` outputs always show that register. Setting a direction bit to 1 enables the stored value with no further write.
- R9: Reading a section configured as output returns its output register, not its pin.
- R10: While a port C half is an output, strobe events leave that half's captured value unchanged. Only the input halves update.
- R11: Control bits 7:6 (address 3) are stored and read back and have no effect on directions, capture or reads.
- R12: The strobe passes through a two-flop synchroniser and an edge detector. A level change set up before clock edge k sets `irq_o` at edge k+2, and not at edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register address: 0 A, 1 B, 2 C, 3 control, 4 status |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| pa_pin_i | input | 8 | Port A pin levels |
| pa_pin_o | output | 8 | Port A output register |
| pa_oe | output | 1 | Port A output enable |
| pb_pin_i | input | 8 | Port B pin levels |
| pb_pin_o | output | 8 | Port B output register |
| pb_oe | output | 1 | Port B output enable |
| pc_pin_i | input | 8 | Port C pin levels |
| pc_pin_o | output | 8 | Port C output register |
| pc_oe | output | 2 | Port C enables: bit 0 for the lower half, bit 1 for the upper half |
| strobe_i | input | 1 | Asynchronous external strobe |
| irq_o | output | 1 | Sticky interrupt request |

## Verification
The assertions assume the strobe is held low while reset is applied, so that leaving reset does not look like a rising edge. They also assume the pins are stable at each sampling clock edge, because the pins feed the capture registers without synchronisation. The stimulus keeps the strobe at 0 through every reset and changes pin values and the strobe only on falling clock edges. After each strobe change it waits at least four cycles before changing again. Capture checks read the ports only after the event has settled.

// File: rtl/pio_pkg.sv
// Shared constants and types for the parallel I/O port group.
// Assumes a 3-bit register address and an 8-bit control word.
package pio_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_PA   = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_PB   = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_PC   = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_STAT = 3'd4;

    localparam int NUM_SECT = 4;

    // Control word, most significant field first
    typedef struct packed {
        logic [1:0]          xfer;        // transfer method, stored only
        logic                fall_edge;   // 1: falling strobe edge is the event
        logic                latch_mode;  // 1: input sections capture on events
        logic [NUM_SECT-1:0] dir;         // {C hi, C lo, B, A}, 1 = output
    } pio_ctrl_t;

endpackage

// File: rtl/pio_edge_det.sv
// Strobe conditioner: brings the asynchronous strobe into the clock domain
// through two flops, then emits a one-cycle event on the selected edge.
// Assumes the strobe is low while reset is applied.
module pio_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    input  logic fall_sel,
    output logic evt_o
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Synchroniser chain plus a delayed copy for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= strobe_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Pick the active edge from the synchronised level pair
    always_comb begin
        if (fall_sel) begin
            evt_o = prev_q & ~sync_q;
        end else begin
            evt_o = sync_q & ~prev_q;
        end
    end

endmodule

// File: rtl/pio_sect.sv
// One port section: an output register, a capture register and the read
// selection. Assumes pin_i is stable at the clock edge where cap is high.
module pio_sect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         is_out,
    input  logic         latch_mode,
    input  logic         cap,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] pin_o,
    output logic [W-1:0] rd_val
);

    logic [W-1:0] out_q;
    logic [W-1:0] lat_q;

    // Output register: loaded by software whatever the direction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (wr) begin
            out_q <= wdata;
        end
    end

    // Capture register: updates only while this section is an input
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (cap && latch_mode && !is_out) begin
            lat_q <= pin_i;
        end
    end

    assign pin_o = out_q;

    // Read source: output register, captured value or live pins
    always_comb begin
        if (is_out) begin
            rd_val = out_q;
        end else if (latch_mode) begin
            rd_val = lat_q;
        end else begin
            rd_val = pin_i;
        end
    end

endmodule

// File: rtl/pio_irq_flag.sv
// Sticky interrupt flag. A set in the same cycle as a clear wins.
// Assumes set is a single-cycle pulse.
module pio_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag_o
);

    logic flag_q;

    // Hold the request until cleared; a new event overrides the clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= set | (flag_q & ~clr);
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/pio_port_group.sv
// Programmable 3-port parallel I/O group with per-half direction on port C,
// live or strobe-captured inputs and a sticky strobe interrupt.
// Assumes PORT_W is even and at least 8; the control word uses the low
// 8 bits of the data bus.
module pio_port_group
    import pio_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [PORT_W-1:0] reg_wdata,
    output logic [PORT_W-1:0] reg_rdata,
    input  logic [PORT_W-1:0] pa_pin_i,
    output logic [PORT_W-1:0] pa_pin_o,
    output logic              pa_oe,
    input  logic [PORT_W-1:0] pb_pin_i,
    output logic [PORT_W-1:0] pb_pin_o,
    output logic              pb_oe,
    input  logic [PORT_W-1:0] pc_pin_i,
    output logic [PORT_W-1:0] pc_pin_o,
    output logic [1:0]        pc_oe,
    input  logic              strobe_i,
    output logic              irq_o
);

    localparam int HALF   = PORT_W / 2;
    localparam int BUS_W  = 3 * PORT_W;
    localparam int CTRL_W = $bits(pio_ctrl_t);

    pio_ctrl_t        ctrl_q;
    logic             latch_mode;
    logic             strb_evt;
    logic             irq_clr;
    logic [BUS_W-1:0] pin_in_bus;
    logic [BUS_W-1:0] pin_out_bus;
    logic [BUS_W-1:0] rd_bus;

    // Control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (reg_wr && reg_addr == ADR_CTRL) begin
            ctrl_q <= pio_ctrl_t'(reg_wdata[CTRL_W-1:0]);
        end
    end

    assign latch_mode = ctrl_q.latch_mode;
    assign irq_clr    = reg_wr && (reg_addr == ADR_STAT) && reg_wdata[0];

    pio_edge_det u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (strobe_i),
        .fall_sel (ctrl_q.fall_edge),
        .evt_o    (strb_evt)
    );

    pio_irq_flag u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (strb_evt),
        .clr    (irq_clr),
        .flag_o (irq_o)
    );

    assign pin_in_bus = {pc_pin_i, pb_pin_i, pa_pin_i};

    // Four sections: A, B, C lower half, C upper half
    for (genvar i = 0; i < NUM_SECT; i++) begin : g_sect
        localparam int SW  = (i < 2) ? PORT_W : HALF;
        localparam int OFF = (i < 2) ? i * PORT_W : 2 * PORT_W + (i - 2) * HALF;
        localparam int WOF = OFF % PORT_W;
        localparam logic [ADDR_W-1:0] SADR =
            (i == 0) ? ADR_PA : (i == 1) ? ADR_PB : ADR_PC;

        logic sect_wr;
        assign sect_wr = reg_wr && (reg_addr == SADR);

        pio_sect #(
            .W (SW)
        ) u_sect (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr         (sect_wr),
            .wdata      (reg_wdata[WOF +: SW]),
            .is_out     (ctrl_q.dir[i]),
            .latch_mode (latch_mode),
            .cap        (strb_evt),
            .pin_i      (pin_in_bus[OFF +: SW]),
            .pin_o      (pin_out_bus[OFF +: SW]),
            .rd_val     (rd_bus[OFF +: SW])
        );
    end

    assign pa_pin_o = pin_out_bus[0 +: PORT_W];
    assign pb_pin_o = pin_out_bus[PORT_W +: PORT_W];
    assign pc_pin_o = pin_out_bus[2*PORT_W +: PORT_W];
    assign pa_oe    = ctrl_q.dir[0];
    assign pb_oe    = ctrl_q.dir[1];
    assign pc_oe    = ctrl_q.dir[3:2];

    // Read decode
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_PA:   reg_rdata = rd_bus[0 +: PORT_W];
            ADR_PB:   reg_rdata = rd_bus[PORT_W +: PORT_W];
            ADR_PC:   reg_rdata = rd_bus[2*PORT_W +: PORT_W];
            ADR_CTRL: reg_rdata[CTRL_W-1:0] = ctrl_q;
            ADR_STAT: reg_rdata[0] = irq_o;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pio_port_group_chk.sv
// Property checker for the port group, attached by bind.
// Assumes the strobe is low during reset and pins are stable at edges.
module pio_port_group_chk
    import pio_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              wclr,
    input logic [PORT_W-1:0] reg_rdata,
    input logic [PORT_W-1:0] pa_pin_i,
    input logic [PORT_W-1:0] pa_pin_o,
    input logic              pa_oe,
    input logic              latch_mode,
    input logic              strb_evt,
    input logic              irq_o
);

    logic clr_req;
    assign clr_req = reg_wr && (reg_addr == ADR_STAT) && wclr;

    AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        strb_evt |=> !strb_evt); // R12

    AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        strb_evt |=> irq_o); // R7

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_req) |=> irq_o); // R7

    AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !strb_evt) |=> !irq_o); // R7

    AST_OUT_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADR_PA && pa_oe) |-> reg_rdata == pa_pin_o); // R9

    AST_LIVE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADR_PA && !pa_oe && !latch_mode) |-> reg_rdata == pa_pin_i); // R4

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == ADR_PA) |=> $stable(pa_pin_o)); // R8

endmodule

bind pio_port_group pio_port_group_chk #(.PORT_W(PORT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .wclr       (reg_wdata[0]),
    .reg_rdata  (reg_rdata),
    .pa_pin_i   (pa_pin_i),
    .pa_pin_o   (pa_pin_o),
    .pa_oe      (pa_oe),
    .latch_mode (latch_mode),
    .strb_evt   (strb_evt),
    .irq_o      (irq_o)
);

// File: tb/pio_port_group_tb_top.sv
`timescale 1ns/1ps
module pio_port_group_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] pa_pin_i = '0, pb_pin_i = '0, pc_pin_i = '0;
    logic [7:0] pa_pin_o, pb_pin_o, pc_pin_o;
    logic       pa_oe, pb_oe;
    logic [1:0] pc_oe;
    logic       strobe_i = 1'b0;
    logic       irq_o;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 0;

    always #2.5 clk = ~clk;

    pio_port_group dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pa_pin_i(pa_pin_i), .pa_pin_o(pa_pin_o), .pa_oe(pa_oe),
        .pb_pin_i(pb_pin_i), .pb_pin_o(pb_pin_o), .pb_oe(pb_oe),
        .pc_pin_i(pc_pin_i), .pc_pin_o(pc_pin_o), .pc_oe(pc_oe),
        .strobe_i(strobe_i), .irq_o(irq_o)
    );

    // ctrl, pin A, pin B, pin C, expected A, B, C, expected {pc_oe, pb_oe, pa_oe}
    // Output registers preloaded with A=11, B=22, C=3C, transparent mode
    localparam logic [63:0] VEC [8] = '{
        64'h00_A5_5A_C3_A5_5A_C3_00,
        64'h01_A5_5A_C3_11_5A_C3_01,
        64'h02_0F_F0_81_0F_22_81_02,
        64'h04_0F_F0_81_0F_F0_8C_04,
        64'h08_0F_F0_81_0F_F0_31_08,
        64'h0F_FF_FF_FF_11_22_3C_0F,
        64'hC0_12_34_56_12_34_56_00,
        64'h8A_66_77_88_66_22_38_0A
    };

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic strobe_to(input logic lvl);
        @(negedge clk);
        strobe_i = lvl;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog (all): actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(3'd3, v); chk("R1", "ctrl", v, 8'h00);
        rd(3'd4, v); chk("R1", "status", v, 8'h00);
        chk("R1", "irq", {7'd0, irq_o}, 8'h00);
        chk("R1", "oe", {4'd0, pc_oe, pb_oe, pa_oe}, 8'h00);
        chk("R1", "pa_out", pa_pin_o, 8'h00);
        chk("R1", "pc_out", pc_pin_o, 8'h00);

        // R8: output registers load while inputs
        wr(3'd0, 8'h11); wr(3'd1, 8'h22); wr(3'd2, 8'h3C);
        chk("R8", "pa_out while input", pa_pin_o, 8'h11);
        chk("R8", "pc_out while input", pc_pin_o, 8'h3C);

        // Table: R2 R3 R4 R9 R11
        foreach (VEC[k]) begin
            wr(3'd3, VEC[k][63:56]);
            pa_pin_i = VEC[k][55:48];
            pb_pin_i = VEC[k][47:40];
            pc_pin_i = VEC[k][39:32];
            rd(3'd0, v); chk("R4/R9", "port A", v, VEC[k][31:24]);
            rd(3'd1, v); chk("R4/R9", "port B", v, VEC[k][23:16]);
            rd(3'd2, v); chk("R3/R9", "port C", v, VEC[k][15:8]);
            chk("R2/R3", "oe", {4'd0, pc_oe, pb_oe, pa_oe}, VEC[k][7:0]);
            rd(3'd3, v); chk("R11", "ctrl readback", v, VEC[k][63:56]);
        end

        // R8: switching to output drives the stored value at once
        wr(3'd3, 8'h00);
        wr(3'd0, 8'h5E);
        chk("R8", "pa_oe off", {7'd0, pa_oe}, 8'h00);
        wr(3'd3, 8'h01);
        chk("R8", "pa_oe on", {7'd0, pa_oe}, 8'h01);
        chk("R8", "pa_out kept", pa_pin_o, 8'h5E);
        wr(3'd3, 8'h00);

        // R12: irq at the third edge after the strobe change, not earlier
        @(negedge clk); strobe_i = 1'b1;
        @(negedge clk);
        @(negedge clk); chk("R12", "irq after 2 edges", {7'd0, irq_o}, 8'h00);
        @(negedge clk); chk("R12", "irq after 3 edges", {7'd0, irq_o}, 8'h01);
        repeat (2) @(negedge clk);

        // R7: write 0 no effect, write 1 clears
        wr(3'd4, 8'h00); chk("R7", "irq after write 0", {7'd0, irq_o}, 8'h01);
        wr(3'd4, 8'h01); chk("R7", "irq after clear", {7'd0, irq_o}, 8'h00);

        // R6: falling edge ignored with rising polarity
        strobe_to(1'b0);
        chk("R6", "irq on falling edge", {7'd0, irq_o}, 8'h00);

        // R5: capture on rising edge
        wr(3'd3, 8'h10);
        pa_pin_i = 8'h3A; pb_pin_i = 8'h4B; pc_pin_i = 8'h5C;
        strobe_to(1'b1);
        pa_pin_i = 8'h00; pb_pin_i = 8'h00; pc_pin_i = 8'h00;
        rd(3'd0, v); chk("R5", "captured A", v, 8'h3A);
        rd(3'd1, v); chk("R5", "captured B", v, 8'h4B);
        rd(3'd2, v); chk("R5", "captured C", v, 8'h5C);
        wr(3'd4, 8'h01);

        // R6: falling polarity captures on fall, ignores rise
        wr(3'd3, 8'h30);
        pa_pin_i = 8'h77; pb_pin_i = 8'h77; pc_pin_i = 8'h77;
        strobe_to(1'b0);
        rd(3'd0, v); chk("R6", "capture on fall", v, 8'h77);
        chk("R6", "irq on fall", {7'd0, irq_o}, 8'h01);
        wr(3'd4, 8'h01);
        pa_pin_i = 8'h99;
        strobe_to(1'b1);
        rd(3'd0, v); chk("R6", "rise ignored data", v, 8'h77);
        chk("R6", "rise ignored irq", {7'd0, irq_o}, 8'h00);

        // R10: output half of C keeps its old captured value
        wr(3'd3, 8'h18);
        strobe_to(1'b0);
        pc_pin_i = 8'hAB;
        strobe_to(1'b1);
        rd(3'd2, v); chk("R10", "C with upper output", v, 8'h3B);
        wr(3'd3, 8'h10);
        pc_pin_i = 8'h00;
        rd(3'd2, v); chk("R10", "C upper not captured", v, 8'h7B);

        // R7: clear in the same cycle as an event keeps irq set
        wr(3'd3, 8'h00);
        wr(3'd4, 8'h01);
        strobe_to(1'b0);
        chk("R7", "irq before race", {7'd0, irq_o}, 8'h00);
        @(negedge clk); strobe_i = 1'b1;
        @(negedge clk);
        @(negedge clk); reg_addr = 3'd4; reg_wdata = 8'h01; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
        chk("R7", "set wins over clear", {7'd0, irq_o}, 8'h01);

        // R1: reset during operation
        wr(3'd3, 8'hFF);
        @(negedge clk); strobe_i = 1'b0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(3'd3, v); chk("R1", "ctrl after reset", v, 8'h00);
        chk("R1", "irq after reset", {7'd0, irq_o}, 8'h00);
        chk("R1", "pa_out after reset", pa_pin_o, 8'h00);

        done = 1;
        finish_run();
    end

endmodule